// File: doc/BRIEF.md
# Two-Phase Serial Link Training Sequencer

This block is the controller that brings up a point-to-point serial display link between a transmitter and a receiver. A start pulse first writes the receiver's training timing fields. The sequencer then runs a series of attempts. Each attempt switches the link off for one cycle, then turns it back on with training pattern 1 at the current drive level, and polls the receiver's bit-lock flag. Once bit lock is seen, the sequencer sends pattern 2 and polls for symbol lock. Each detected lock flag is cleared with a one-cycle write-one-to-clear pulse before the sequencer moves on.

Four drive levels, each a pairing of output swing and pre-emphasis, are each tried twice, for eight attempts at most. After symbol lock, the link goes to normal traffic with enhanced framing. After one idle-pattern time, frame-start and frame-end error correction come on and done is raised, together with the index of the level that trained. If every attempt fails, fail is raised and the link stays enabled in pattern 1. Both end states hold until the next start pulse. The lock inputs are asynchronous and pass through a two-flop synchroniser. The poll spacing is derived from the clock frequency parameter.

Top module: `lt_train_seq`

## Requirements
- R1: After reset the link is idle: tx_en, rx_en, done, fail, enh_frame, err_corr_en and all clear pulses are 0, pattern is 00 (cleared) and swing_idx is 0.
- R2: A start pulse in the idle, done or fail state gives a one-cycle rx_misc_wr in the next cycle, with rx_tp_code = 01 (the 48 setting) and rx_delay_code = 10 (the 90 setting). A start pulse while training is in progress has no effect.
- R3: Every attempt begins with one cycle in which tx_en = rx_en = 0 and pattern = 00. In the next cycle both enables are 1 and pattern = 01 (training pattern 1).
- R4: swing_idx equals the attempt number (0 to 7) divided by 2. drive_code is {swing[1:0], emphasis[1:0]} with swing 00 = 400 mV, 01 = 600 mV, 10 = 800 mV and emphasis 00 = 0 dB, 01 = 3.5 dB, 10 = 6 dB. Levels 0 to 3 therefore give 0000, 0010, 0101 and 1000.
- R5: The synchronised bit-lock flag is sampled every CLK_MHZ/2 cycles (0.5 us) from the start of pattern 1, up to 4 times. A lock input is seen by the sequencer on the third rising edge after it changes.
- R6: When bit lock is sampled high, clr_bit_lock pulses for one cycle while pattern stays 01. Pattern 10 (training pattern 2) follows in the next cycle.
- R7: The synchronised symbol-lock flag is sampled every 3*CLK_MHZ/2 cycles (1.5 us) from the start of pattern 2, up to 4 times. When it is sampled high, clr_sym_lock pulses for one cycle.
- R8: If the fourth sample of either flag is low, the next attempt begins. A flag that is high on the fourth sample counts as a lock.
- R9: After clr_sym_lock, pattern becomes 11 (normal) with enh_frame = 1. IDLE_GAP cycles later, err_corr_en and done rise and win_level shows the level that trained. These hold until the next start pulse.
- R10: If all 8 attempts fail, fail = 1 with tx_en = rx_en = 1, pattern = 01 and swing_idx = 3. This holds until the next start pulse. done and fail are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin training (one-cycle pulse) |
| bit_lock_in | input | 1 | Receiver bit-lock flag, asynchronous |
| sym_lock_in | input | 1 | Receiver symbol-lock flag, asynchronous |
| tx_en | output | 1 | Transmitter enable |
| rx_en | output | 1 | Receiver enable |
| pattern | output | 2 | 00 cleared, 01 pattern 1, 10 pattern 2, 11 normal |
| swing_idx | output | 2 | Current drive level index |
| drive_code | output | 4 | Swing and emphasis code of the current level |
| enh_frame | output | 1 | Enhanced framing on both ends |
| err_corr_en | output | 1 | Frame-start and frame-end error correction |
| clr_bit_lock | output | 1 | Write-one-to-clear pulse for the bit-lock flag |
| clr_sym_lock | output | 1 | Write-one-to-clear pulse for the symbol-lock flag |
| rx_misc_wr | output | 1 | Write strobe for the receiver timing fields |
| rx_tp_code | output | 2 | Pattern-1-to-pattern-2 timing code |
| rx_delay_code | output | 2 | Receiver delay code |
| done | output | 1 | Training succeeded |
| fail | output | 1 | All attempts failed |
| win_level | output | 2 | Level that trained, valid with done |

## Verification
The critical coincidence is a lock flag reaching the sequencer on the same edge as the fourth and final sample of its phase, where the sequencer must choose between accepting the lock and starting the next attempt. The bench produces it by making the lock appear a fixed number of cycles after the pattern starts and sweeping that delay by single cycles across the last sample, for both the bit-lock and the symbol-lock phases. A behavioural model in the bench predicts every output on every clock, and after each run the final done, fail and level values are compared against expectations worked out by hand. A second coincidence, a start pulse arriving while a phase is polling, is provoked mid-run and must leave the sequence undisturbed.

// File: rtl/lt_seq_pkg.sv
package lt_seq_pkg;

    localparam int NUM_LEVELS = 4;

    typedef enum logic [1:0] {
        PAT_CLR  = 2'b00,
        PAT_ONE  = 2'b01,
        PAT_TWO  = 2'b10,
        PAT_NORM = 2'b11
    } pat_e;

    typedef enum logic [3:0] {
        ST_IDLE, ST_CFG, ST_DIS, ST_P1, ST_ACK1,
        ST_P2, ST_ACK2, ST_NORM, ST_DONE, ST_FAIL
    } st_e;

    localparam logic [1:0] RX_TP_48  = 2'b01;
    localparam logic [1:0] RX_DLY_90 = 2'b10;

    typedef struct packed {
        logic tx_en;
        logic rx_en;
        pat_e pat;
        logic enh;
        logic ecc;
        logic ack_bit;
        logic ack_sym;
        logic misc_wr;
        logic done;
        logic fail;
    } link_ctl_t;

    // {swing, emphasis}: swing 00=400mV 01=600mV 10=800mV; emph 00=0dB 01=3.5dB 10=6dB
    function automatic logic [3:0] level_drive(input logic [1:0] lvl);
        case (lvl)
            2'd0:    return 4'b0000;
            2'd1:    return 4'b0010;
            2'd2:    return 4'b0101;
            default: return 4'b1000;
        endcase
    endfunction

    function automatic link_ctl_t ctl_for(input st_e s);
        link_ctl_t c;
        c = '0;
        c.pat = PAT_CLR;
        case (s)
            ST_CFG:  c.misc_wr = 1'b1;
            ST_P1:   begin c.tx_en = 1'b1; c.rx_en = 1'b1; c.pat = PAT_ONE; end
            ST_ACK1: begin c.tx_en = 1'b1; c.rx_en = 1'b1; c.pat = PAT_ONE; c.ack_bit = 1'b1; end
            ST_P2:   begin c.tx_en = 1'b1; c.rx_en = 1'b1; c.pat = PAT_TWO; end
            ST_ACK2: begin c.tx_en = 1'b1; c.rx_en = 1'b1; c.pat = PAT_TWO; c.ack_sym = 1'b1; end
            ST_NORM: begin c.tx_en = 1'b1; c.rx_en = 1'b1; c.pat = PAT_NORM; c.enh = 1'b1; end
            ST_DONE: begin
                c.tx_en = 1'b1; c.rx_en = 1'b1; c.pat = PAT_NORM;
                c.enh = 1'b1; c.ecc = 1'b1; c.done = 1'b1;
            end
            ST_FAIL: begin c.tx_en = 1'b1; c.rx_en = 1'b1; c.pat = PAT_ONE; c.fail = 1'b1; end
            default: c = c;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/lt_sync.sv
module lt_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [STAGES-1:0][WIDTH-1:0] stg;

    always_ff @(posedge clk) begin
        if (rst) begin
            stg <= '0;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) begin
                stg[i] <= stg[i-1];
            end
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/lt_gap_timer.sv
module lt_gap_timer #(
    parameter int W = 7
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         restart,
    input  logic [W-1:0] last,
    output logic         expired
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            cnt <= '0;
        end else if (cnt != last) begin
            cnt <= cnt + W'(1);
        end
    end

    assign expired = (cnt == last);

    // R5: a window that has run out stays run out until restarted
    p_hold_at_limit_r5: assert property (@(posedge clk) disable iff (rst)
        (expired && !restart) |=> expired);
endmodule

// File: rtl/lt_train_seq.sv
module lt_train_seq
    import lt_seq_pkg::*;
#(
    parameter int CLK_MHZ         = 50,
    parameter int TRIES_PER_LEVEL = 2,
    parameter int POLL_LIMIT      = 4,
    parameter int IDLE_GAP        = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic       bit_lock_in,
    input  logic       sym_lock_in,
    output logic       tx_en,
    output logic       rx_en,
    output logic [1:0] pattern,
    output logic [1:0] swing_idx,
    output logic [3:0] drive_code,
    output logic       enh_frame,
    output logic       err_corr_en,
    output logic       clr_bit_lock,
    output logic       clr_sym_lock,
    output logic       rx_misc_wr,
    output logic [1:0] rx_tp_code,
    output logic [1:0] rx_delay_code,
    output logic       done,
    output logic       fail,
    output logic [1:0] win_level
);
    localparam int BIT_GAP  = (CLK_MHZ + 1) / 2;
    localparam int SYM_GAP  = (3 * CLK_MHZ + 1) / 2;
    localparam int ATTEMPTS = NUM_LEVELS * TRIES_PER_LEVEL;
    localparam int AW       = $clog2(ATTEMPTS);
    localparam int PW       = $clog2(POLL_LIMIT);
    localparam int MAX_GAP  = (SYM_GAP > IDLE_GAP) ? SYM_GAP : IDLE_GAP;
    localparam int TW       = $clog2(MAX_GAP + 1);

    st_e          state_q, state_d;
    logic [AW-1:0] att_q, att_d;
    logic [PW-1:0] poll_q, poll_d;
    logic          poll_retry, tmr_restart, expired;
    logic [TW-1:0] gap_last;
    logic [1:0]    lock_s;
    logic [1:0]    lvl_w;
    link_ctl_t     ctl;

    lt_sync #(.WIDTH(2), .STAGES(2)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({sym_lock_in, bit_lock_in}),
        .q   (lock_s)
    );

    always_comb begin
        case (state_q)
            ST_P1:   gap_last = TW'(BIT_GAP - 1);
            ST_P2:   gap_last = TW'(SYM_GAP - 1);
            ST_NORM: gap_last = TW'(IDLE_GAP - 1);
            default: gap_last = '0;
        endcase
    end

    lt_gap_timer #(.W(TW)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .restart (tmr_restart),
        .last    (gap_last),
        .expired (expired)
    );

    always_comb begin
        state_d    = state_q;
        att_d      = att_q;
        poll_d     = poll_q;
        poll_retry = 1'b0;
        case (state_q)
            ST_IDLE, ST_DONE, ST_FAIL: begin
                if (start) begin
                    state_d = ST_CFG;
                    att_d   = '0;
                end
            end
            ST_CFG:  state_d = ST_DIS;
            ST_DIS:  begin state_d = ST_P1; poll_d = '0; end
            ST_P1, ST_P2: begin
                if (expired) begin
                    if ((state_q == ST_P1) ? lock_s[0] : lock_s[1]) begin
                        state_d = (state_q == ST_P1) ? ST_ACK1 : ST_ACK2;
                    end else if (poll_q == PW'(POLL_LIMIT - 1)) begin
                        if (att_q == AW'(ATTEMPTS - 1)) begin
                            state_d = ST_FAIL;
                        end else begin
                            att_d   = att_q + AW'(1);
                            state_d = ST_DIS;
                        end
                    end else begin
                        poll_d     = poll_q + PW'(1);
                        poll_retry = 1'b1;
                    end
                end
            end
            ST_ACK1: begin state_d = ST_P2; poll_d = '0; end
            ST_ACK2: state_d = ST_NORM;
            ST_NORM: if (expired) state_d = ST_DONE;
            default: state_d = ST_IDLE;
        endcase
    end

    assign tmr_restart = (state_d != state_q) || poll_retry;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            att_q   <= '0;
            poll_q  <= '0;
        end else begin
            state_q <= state_d;
            att_q   <= att_d;
            poll_q  <= poll_d;
        end
    end

    assign ctl           = ctl_for(state_q);
    assign lvl_w         = 2'(att_q / AW'(TRIES_PER_LEVEL));
    assign tx_en         = ctl.tx_en;
    assign rx_en         = ctl.rx_en;
    assign pattern       = ctl.pat;
    assign enh_frame     = ctl.enh;
    assign err_corr_en   = ctl.ecc;
    assign clr_bit_lock  = ctl.ack_bit;
    assign clr_sym_lock  = ctl.ack_sym;
    assign rx_misc_wr    = ctl.misc_wr;
    assign done          = ctl.done;
    assign fail          = ctl.fail;
    assign swing_idx     = lvl_w;
    assign drive_code    = level_drive(lvl_w);
    assign win_level     = ctl.done ? lvl_w : 2'b00;
    assign rx_tp_code    = RX_TP_48;
    assign rx_delay_code = RX_DLY_90;

    // R2: timing-field write only follows a start pulse
    p_misc_after_start_r2: assert property (@(posedge clk) disable iff (rst)
        rx_misc_wr |-> $past(start));
    // R2: start during training is ignored
    p_busy_ignores_start_r2: assert property (@(posedge clk) disable iff (rst)
        (start && !(state_q inside {ST_IDLE, ST_DONE, ST_FAIL})) |=> !rx_misc_wr);
    // R3: disable cycle is followed by pattern 1 with both ends enabled
    p_dis_then_pat1_r3: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_DIS) |=> (tx_en && rx_en && pattern == PAT_ONE));
    // R4: drive level does not move while the link stays enabled
    p_swing_steady_r4: assert property (@(posedge clk) disable iff (rst)
        (tx_en && $past(tx_en)) |-> $stable(swing_idx));
    // R6: bit-lock clear pulse is followed by pattern 2
    p_ack_bit_then_pat2_r6: assert property (@(posedge clk) disable iff (rst)
        clr_bit_lock |=> (pattern == PAT_TWO && !clr_bit_lock));
    // R7 / R9: symbol-lock clear pulse is followed by normal framing
    p_ack_sym_then_norm_r7: assert property (@(posedge clk) disable iff (rst)
        clr_sym_lock |=> (pattern == PAT_NORM && enh_frame && !done));
    // R9: done and its level hold until start
    p_done_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> (done && $stable(win_level)));
    // R10: fail holds, link left enabled in pattern 1
    p_fail_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (fail && !start) |=> (fail && tx_en && pattern == PAT_ONE));
    p_done_fail_excl_r10: assert property (@(posedge clk) disable iff (rst)
        !(done && fail));
endmodule

// File: tb/lt_train_seq_tb_top.sv
module lt_train_seq_tb_top;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic bit_lock_in = 1'b0;
    logic sym_lock_in = 1'b0;
    logic tx_en, rx_en, enh_frame, err_corr_en, clr_bit_lock, clr_sym_lock;
    logic rx_misc_wr, done, fail;
    logic [1:0] pattern, swing_idx, rx_tp_code, rx_delay_code, win_level;
    logic [3:0] drive_code;

    always #10 clk = ~clk;

    lt_train_seq dut_i (
        .clk(clk), .rst(rst), .start(start),
        .bit_lock_in(bit_lock_in), .sym_lock_in(sym_lock_in),
        .tx_en(tx_en), .rx_en(rx_en), .pattern(pattern), .swing_idx(swing_idx),
        .drive_code(drive_code), .enh_frame(enh_frame), .err_corr_en(err_corr_en),
        .clr_bit_lock(clr_bit_lock), .clr_sym_lock(clr_sym_lock),
        .rx_misc_wr(rx_misc_wr), .rx_tp_code(rx_tp_code), .rx_delay_code(rx_delay_code),
        .done(done), .fail(fail), .win_level(win_level)
    );

    localparam int GAP_B = 25;   // 0.5 us at 50 MHz
    localparam int GAP_S = 75;   // 1.5 us at 50 MHz
    localparam int GAP_I = 16;

    int n_chk = 0;
    int n_bad = 0;
    bit armed = 0;

    // receiver knobs
    int k_bit_lvl = 0, k_bit_dly = 0, k_sym_lvl = 0, k_sym_dly = 0;
    int age1 = 0, age2 = 0;

    // behavioural reference: phase 0 idle,1 cfg,2 off,3 pat1,4 ack1,5 pat2,6 ack2,7 normal,8 done,9 fail
    int m_ph = 0, m_att = 0, m_poll = 0, m_el = 0;
    bit m_b1 = 0, m_b2 = 0, m_s1 = 0, m_s2 = 0;

    task automatic check(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    function automatic int drv_tab(input int lvl);
        case (lvl)
            0: return 4'b0000;
            1: return 4'b0010;
            2: return 4'b0101;
            default: return 4'b1000;
        endcase
    endfunction

    always @(posedge clk) begin
        int nph;
        if (rst) begin
            m_ph = 0; m_att = 0; m_poll = 0; m_el = 0;
            m_b1 = 0; m_b2 = 0; m_s1 = 0; m_s2 = 0;
        end else begin
            nph = m_ph;
            if (m_ph == 0 || m_ph == 8 || m_ph == 9) begin
                if (start) begin nph = 1; m_att = 0; end
            end else if (m_ph == 1) nph = 2;
            else if (m_ph == 2) begin nph = 3; m_poll = 0; end
            else if (m_ph == 3 || m_ph == 5) begin
                if (m_el == ((m_ph == 3) ? GAP_B : GAP_S) - 1) begin
                    if ((m_ph == 3) ? m_b2 : m_s2) nph = m_ph + 1;
                    else if (m_poll == 3) begin
                        if (m_att == 7) nph = 9;
                        else begin m_att++; nph = 2; end
                    end else begin
                        m_poll++;
                        m_el = -1;
                    end
                end
            end else if (m_ph == 4) begin nph = 5; m_poll = 0; end
            else if (m_ph == 6) nph = 7;
            else if (m_ph == 7) begin
                if (m_el == GAP_I - 1) nph = 8;
            end
            if (nph != m_ph) m_el = 0; else m_el++;
            m_ph = nph;
            m_b2 = m_b1; m_b1 = bit_lock_in;
            m_s2 = m_s1; m_s1 = sym_lock_in;
        end
    end

    always @(negedge clk) begin
        int ep;
        if (armed) begin
            ep = (m_ph == 3 || m_ph == 4 || m_ph == 9) ? 1 :
                 (m_ph == 5 || m_ph == 6) ? 2 : (m_ph == 7 || m_ph == 8) ? 3 : 0;
            check("R3", "enables/pattern", {tx_en, rx_en, pattern},
                  {(m_ph >= 3) ? 2'b11 : 2'b00, 2'(ep)});
            check("R4", "swing/drive", {swing_idx, drive_code},
                  {2'(m_att / 2), 4'(drv_tab(m_att / 2))});
            check("R6", "clr_bit_lock", clr_bit_lock, (m_ph == 4) ? 1 : 0);
            check("R7", "clr_sym_lock", clr_sym_lock, (m_ph == 6) ? 1 : 0);
            check("R2", "rx timing write", {rx_misc_wr, rx_tp_code, rx_delay_code},
                  {(m_ph == 1) ? 1'b1 : 1'b0, 2'b01, 2'b10});
            check("R9", "enh/ecc/done/level", {enh_frame, err_corr_en, done, win_level},
                  {(m_ph == 7 || m_ph == 8) ? 1'b1 : 1'b0, (m_ph == 8) ? 2'b11 : 2'b00,
                   (m_ph == 8) ? 2'(m_att / 2) : 2'b00});
            check("R10", "fail", fail, (m_ph == 9) ? 1 : 0);
        end
        // receiver model driven from the link outputs
        age1 = (tx_en && pattern == 2'b01) ? age1 + 1 : 0;
        age2 = (tx_en && pattern == 2'b10) ? age2 + 1 : 0;
        bit_lock_in <= tx_en && pattern == 2'b01 && int'(swing_idx) >= k_bit_lvl && age1 >= k_bit_dly;
        sym_lock_in <= tx_en && pattern == 2'b10 && int'(swing_idx) >= k_sym_lvl && age2 >= k_sym_dly;
    end

    task automatic pulse_start();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
    endtask

    task automatic run_case(input string req, input int bl, input int bd, input int sl, input int sd,
                            input bit mid_start, input bit exp_done, input int exp_lvl);
        int guard;
        k_bit_lvl = bl; k_bit_dly = bd; k_sym_lvl = sl; k_sym_dly = sd;
        pulse_start();
        if (mid_start) begin
            repeat (40) @(negedge clk);
            pulse_start();
        end
        guard = 0;
        while (!(m_ph == 8 || m_ph == 9) && guard < 20000) begin
            @(negedge clk);
            guard++;
        end
        repeat (5) @(negedge clk);
        check(req, "done", done, exp_done ? 1 : 0);
        check(req, "fail", fail, exp_done ? 0 : 1);
        if (exp_done) begin
            check(req, "win_level", win_level, exp_lvl);
            check("R4", "drive_code at win", drive_code, drv_tab(exp_lvl));
        end else begin
            check("R10", "fail swing", swing_idx, 3);
            check("R10", "fail pattern", pattern, 1);
        end
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1", "reset enables/pattern", {tx_en, rx_en, pattern}, 0);
        check("R1", "reset status", {done, fail, enh_frame, err_corr_en, swing_idx}, 0);
        armed = 1;
        run_case("R9", 0, 0, 0, 0, 0, 1, 0);
        run_case("R5", 0, 60, 0, 0, 0, 1, 0);
        run_case("R8", 2, 0, 0, 0, 0, 1, 2);
        run_case("R7", 0, 0, 3, 0, 0, 1, 3);
        run_case("R8", 0, 97, 0, 0, 0, 1, 0);
        run_case("R8", 0, 98, 0, 0, 0, 1, 0);
        run_case("R8", 0, 99, 0, 0, 0, 0, 0);
        run_case("R7", 0, 0, 0, 298, 0, 1, 0);
        run_case("R7", 0, 0, 0, 299, 0, 0, 0);
        run_case("R10", 5, 0, 0, 0, 0, 0, 0);
        run_case("R2", 1, 0, 0, 100, 1, 1, 1);
        run_case("R10", 0, 0, 5, 0, 0, 0, 0);
        run_case("R9", 3, 10, 0, 0, 0, 1, 3);
        repeat (30) @(negedge clk);
        check("R9", "done held", done, 1);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule